// File: doc/BRIEF.md
# Microprogrammed 8-bit Processor Core

This block is a compact 8-bit processor whose every cycle is steered by a 24-bit control word read from a fixed on-chip microcode table. The table is indexed by the low opcode bits of the instruction register joined with a 3-bit micro-step count. One control bit ends an instruction and sends the step count back to the fetch step. Another bit stops the sequencer for good. Data moves over one internal byte bus. That bus is driven either by the memory read path or by an ALU. The ALU's right-hand operand comes from a 2-bit selector: X, T, memory read data, or a constant zero.

A 3-bit destination field, qualified by a load bit, is decoded into eight active-low byte strobes. The targets are A, X, T, the two PC halves, the two address-register halves and a memory write. Memory is modelled inside the block. The lower half of the 16-bit space is a program ROM whose bytes come from a parameter, repeated every `ROM_DEPTH` bytes. The upper half is a small RAM, cleared by reset and repeated every `RAM_DEPTH` bytes. Three instructions are implemented. A program's behaviour is seen on the address bus, the internal data bus and a halted flag.

Top module: `ucode_cpu`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, addr_o is 0x0000, halted_o is 0 and data_o shows ROM byte 0, so the first opcode comes from address 0x0000.
- R2: Opcode 0x00 (no-operation) takes two cycles, a fetch and one empty step. The address advances by one after the fetch.
- R3: Opcode 0x01 (jump) is followed by a low target byte and then a high target byte. Both operand bytes are read from consecutive addresses before the PC takes the target. The instruction takes four cycles.
- R4: In the last jump step, data_o carries the low target byte, passed through the ALU from T with the right-operand select set to T. addr_o still shows the pre-jump PC in that step.
- R5: The program 00 00 01 01 00 repeats a six-cycle address pattern 1,2,2,3,4,5 indefinitely.
- R6: Opcode 0x02 (halt) asserts halted_o one cycle after its execution step. From that step onward, addr_o holds the address after the halt opcode and data_o reads 0x00 through the zero right-operand code (select value 3), even when ROM at that address is nonzero.
- R7: Pulling rst_ni low while halted clears halted_o, and the program restarts from 0x0000.
- R8: In any cycle at most one of the eight active-low load strobes is low, and none is low when the control word's load bit is clear. The PC halves change only through their own strobes.
- R9: Address bit 15 set selects RAM and clear selects ROM. Reset clears RAM, so a jump to 0x8000 executes no-operations from RAM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_o | output | 16 | Current memory address (PC or address register) |
| data_o | output | 8 | Internal data bus value |
| halted_o | output | 1 | High once a halt instruction has executed |

## Verification
Every result is combinational from state that changed at the preceding clock edge. So the address and bus value for micro-step k are due exactly k rising edges after reset release. halted_o lags the halt step by one further edge, because it is a register. The bench releases reset on a falling edge and samples one time unit later. It then advances one falling edge per step and compares each instance against a per-cycle table worked out by hand from the step counts in R2, R3 and R6. Long-run checks wait an exact multiple of the six-cycle loop period, so the expected value is known without tracking intermediate cycles.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int CW_W = 24;

  typedef enum logic [2:0] {
    DST_A, DST_X, DST_T, DST_PCL, DST_PCH, DST_ARL, DST_ARH, DST_MEM
  } dst_e;
  typedef enum logic [1:0] {RS_X, RS_T, RS_MEM, RS_ZERO} rsel_e;
  typedef enum logic [1:0] {OP_PASS, OP_ADD, OP_AND, OP_OR} aop_e;
  typedef enum logic {BUS_MEM, BUS_ALU} bus_e;
  typedef enum logic {ADR_PC, ADR_AR} adr_e;

  typedef struct packed {
    logic [9:0] rsvd;
    logic       end_op;
    logic       halt;
    logic       ir_ld;
    logic       pc_inc;
    adr_e       addr_sel;
    bus_e       bus_sel;
    logic       ld_en;
    dst_e       dst;
    rsel_e      r_sel;
    aop_e       alu_op;
  } cw_t;

  localparam int OPC_NOP  = 0;
  localparam int OPC_JMP  = 1;
  localparam int OPC_HALT = 2;

  function automatic cw_t ucode_word(input int op, input int step);
    cw_t w;
    w = '0;
    if (step == 0) begin
      w.ir_ld  = 1'b1;
      w.pc_inc = 1'b1;
    end else if (op == OPC_JMP) begin
      case (step)
        1: begin w.ld_en = 1'b1; w.dst = DST_T;   w.pc_inc = 1'b1; end
        2: begin w.ld_en = 1'b1; w.dst = DST_PCH; w.pc_inc = 1'b1; end
        3: begin
          w.bus_sel = BUS_ALU; w.r_sel = RS_T; w.alu_op = OP_PASS;
          w.ld_en = 1'b1; w.dst = DST_PCL; w.end_op = 1'b1;
        end
        default: w.end_op = 1'b1;
      endcase
    end else if (op == OPC_HALT && step == 1) begin
      w.halt = 1'b1; w.bus_sel = BUS_ALU; w.r_sel = RS_ZERO; w.alu_op = OP_PASS;
    end else begin
      w.end_op = 1'b1;
    end
    return w;
  endfunction
endpackage

// File: rtl/cpu_useq.sv
module cpu_useq
  import cpu_pkg::*;
#(
  parameter int OP_W   = 2,
  parameter int STEP_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] op_i,
  output cw_t             cw_o,
  output logic            halted_o
);
  localparam int UA_W   = OP_W + STEP_W;
  localparam int UROM_N = 2 ** UA_W;

  cw_t urom [UROM_N];
  for (genvar g = 0; g < UROM_N; g++) begin : g_urom
    localparam int OPV = g / (2 ** STEP_W);
    localparam int STV = g % (2 ** STEP_W);
    assign urom[g] = ucode_word(OPV, STV);
  end

  logic [OP_W-1:0]   ir_q;
  logic [STEP_W-1:0] step_q;
  logic              halted_q;

  assign cw_o     = urom[{ir_q, step_q}];
  assign halted_o = halted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q     <= '0;
      step_q   <= '0;
      halted_q <= 1'b0;
    end else if (!halted_q) begin
      if (cw_o.ir_ld) ir_q <= op_i;
      if (cw_o.halt)        halted_q <= 1'b1;
      else if (cw_o.end_op) step_q   <= '0;
      else                  step_q   <= step_q + 1'b1;
    end
  end
endmodule

// File: rtl/cpu_ld_dec.sv
module cpu_ld_dec #(
  parameter int DST_W = 3,
  localparam int N_DST = 2 ** DST_W
) (
  input  logic             en_i,
  input  logic [DST_W-1:0] dst_i,
  output logic [N_DST-1:0] ld_no
);
  for (genvar g = 0; g < N_DST; g++) begin : g_strobe
    assign ld_no[g] = !(en_i && (dst_i == DST_W'(g)));
  end
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] t_i,
  input  logic [DW-1:0] mem_i,
  input  rsel_e         r_sel_i,
  input  aop_e          op_i,
  output logic [DW-1:0] y_o
);
  logic [DW-1:0] r;

  always_comb begin
    unique case (r_sel_i)
      RS_X:    r = x_i;
      RS_T:    r = t_i;
      RS_MEM:  r = mem_i;
      default: r = '0;
    endcase
  end

  always_comb begin
    unique case (op_i)
      OP_PASS: y_o = r;
      OP_ADD:  y_o = a_i + r;
      OP_AND:  y_o = a_i & r;
      default: y_o = a_i | r;
    endcase
  end
endmodule

// File: rtl/cpu_mem.sv
module cpu_mem #(
  parameter int DW        = 8,
  parameter int AW        = 16,
  parameter int ROM_DEPTH = 8,
  parameter int RAM_DEPTH = 16,
  parameter logic [DW*ROM_DEPTH-1:0] PROG = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_ni,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int ROM_AW = $clog2(ROM_DEPTH);
  localparam int RAM_AW = $clog2(RAM_DEPTH);
  localparam int MAX_AW = (ROM_AW > RAM_AW) ? ROM_AW : RAM_AW;

  logic [DW-1:0] rom [ROM_DEPTH];
  logic [DW-1:0] ram [RAM_DEPTH];
  logic          rom_cs_n, ram_cs_n;
  logic          unused_hi;

  for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_rom
    assign rom[g] = PROG[g*DW +: DW];
  end

  assign rom_cs_n  = addr_i[AW-1];
  assign ram_cs_n  = !addr_i[AW-1];
  assign unused_hi = ^addr_i[AW-2:MAX_AW];

  assign rdata_o = !rom_cs_n ? rom[addr_i[ROM_AW-1:0]] : ram[addr_i[RAM_AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < RAM_DEPTH; i++) ram[i] <= '0;
    end else if (!wr_ni && !ram_cs_n) begin
      ram[addr_i[RAM_AW-1:0]] <= wdata_i;
    end
  end
endmodule

// File: rtl/ucode_cpu.sv
module ucode_cpu
  import cpu_pkg::*;
#(
  parameter int ROM_DEPTH = 8,
  parameter int RAM_DEPTH = 16,
  parameter logic [8*ROM_DEPTH-1:0] PROG = 64'h0000_0000_0101_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic [15:0] addr_o,
  output logic [7:0]  data_o,
  output logic        halted_o
);
  localparam int DW     = 8;
  localparam int AW     = 16;
  localparam int OP_W   = 2;
  localparam int STEP_W = 3;
  localparam int DST_W  = 3;

  cw_t            cw;
  logic [7:0]     ld_n;
  logic [DW-1:0]  bus, alu_y, mem_rd;
  logic [DW-1:0]  a_q, x_q, t_q;
  logic [AW-1:0]  pc_q, ar_q, pc_nxt, ar_nxt;
  logic           unused_rsvd;

  assign unused_rsvd = ^cw.rsvd;

  cpu_useq #(.OP_W(OP_W), .STEP_W(STEP_W)) u_useq (
    .clk_i, .rst_ni, .op_i(bus[OP_W-1:0]), .cw_o(cw), .halted_o
  );

  cpu_ld_dec #(.DST_W(DST_W)) u_dec (
    .en_i(cw.ld_en), .dst_i(cw.dst), .ld_no(ld_n)
  );

  cpu_alu #(.DW(DW)) u_alu (
    .a_i(a_q), .x_i(x_q), .t_i(t_q), .mem_i(mem_rd),
    .r_sel_i(cw.r_sel), .op_i(cw.alu_op), .y_o(alu_y)
  );

  cpu_mem #(.DW(DW), .AW(AW), .ROM_DEPTH(ROM_DEPTH), .RAM_DEPTH(RAM_DEPTH), .PROG(PROG)) u_mem (
    .clk_i, .rst_ni, .addr_i(addr_o), .wr_ni(ld_n[DST_MEM]), .wdata_i(bus), .rdata_o(mem_rd)
  );

  assign addr_o = (cw.addr_sel == ADR_AR) ? ar_q : pc_q;
  assign bus    = (cw.bus_sel == BUS_ALU) ? alu_y : mem_rd;
  assign data_o = bus;

  always_comb begin
    pc_nxt = pc_q + {{(AW-1){1'b0}}, cw.pc_inc};
    if (!ld_n[DST_PCL]) pc_nxt[7:0]  = bus;
    if (!ld_n[DST_PCH]) pc_nxt[15:8] = bus;
    ar_nxt = ar_q;
    if (!ld_n[DST_ARL]) ar_nxt[7:0]  = bus;
    if (!ld_n[DST_ARH]) ar_nxt[15:8] = bus;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q  <= '0;
      x_q  <= '0;
      t_q  <= '0;
      pc_q <= '0;
      ar_q <= '0;
    end else begin
      if (!ld_n[DST_A]) a_q <= bus;
      if (!ld_n[DST_X]) x_q <= bus;
      if (!ld_n[DST_T]) t_q <= bus;
      pc_q <= pc_nxt;
      ar_q <= ar_nxt;
    end
  end
endmodule

// File: rtl/ucode_cpu_chk.sv
module ucode_cpu_chk
  import cpu_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] addr_o,
  input logic [7:0]  data_o,
  input logic        halted_o,
  input cw_t         cw,
  input logic [7:0]  ld_n,
  input logic [7:0]  alu_y
);
  p_one_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~ld_n));

  p_no_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cw.ld_en |-> (ld_n == 8'hFF));

  p_fetch_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cw.ir_ld && !halted_o) |=> (addr_o == $past(addr_o) + 16'd1));

  p_jmp_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_n[DST_PCH] |=> (addr_o[15:8] == $past(data_o)));

  p_halt_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && $stable(addr_o)));

  p_halt_bus_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> (data_o == 8'h00));

  p_zero_operand_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cw.r_sel == RS_ZERO && cw.alu_op == OP_PASS) |-> (alu_y == 8'h00));
endmodule

bind ucode_cpu ucode_cpu_chk u_chk (
  .clk_i, .rst_ni, .addr_o, .data_o, .halted_o,
  .cw(cw), .ld_n(ld_n), .alu_y(alu_y)
);

// File: tb/ucode_cpu_test.sv
module ucode_cpu_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;

  logic [15:0] l_addr, r_addr, h_addr;
  logic [7:0]  l_data, r_data, h_data;
  logic        l_halt, r_halt, h_halt;

  always #(CLK_PERIOD/2) clk = ~clk;

  // loop: 00 00 01 01 00 ; jump to RAM: 01 00 80 ; halt: 00 02 55
  ucode_cpu #(.PROG(64'h0000_0000_0101_0000)) uut (
    .clk_i(clk), .rst_ni, .addr_o(l_addr), .data_o(l_data), .halted_o(l_halt));
  ucode_cpu #(.PROG(64'h0000_0000_0080_0001)) uut_ram (
    .clk_i(clk), .rst_ni, .addr_o(r_addr), .data_o(r_data), .halted_o(r_halt));
  ucode_cpu #(.PROG(64'h0000_0000_0055_0200)) uut_halt (
    .clk_i(clk), .rst_ni, .addr_o(h_addr), .data_o(h_data), .halted_o(h_halt));

  // {loop addr,data, ram addr,data, halt addr,data} per cycle after reset release
  localparam logic [71:0] VEC [NVEC] = '{
    {16'h0000, 8'h00, 16'h0000, 8'h01, 16'h0000, 8'h00},
    {16'h0001, 8'h00, 16'h0001, 8'h00, 16'h0001, 8'h02},
    {16'h0001, 8'h00, 16'h0002, 8'h80, 16'h0001, 8'h02},
    {16'h0002, 8'h01, 16'h8003, 8'h00, 16'h0002, 8'h00},
    {16'h0002, 8'h01, 16'h8000, 8'h00, 16'h0002, 8'h00},
    {16'h0003, 8'h01, 16'h8001, 8'h00, 16'h0002, 8'h00},
    {16'h0004, 8'h00, 16'h8001, 8'h00, 16'h0002, 8'h00},
    {16'h0005, 8'h01, 16'h8002, 8'h00, 16'h0002, 8'h00},
    {16'h0001, 8'h00, 16'h8002, 8'h00, 16'h0002, 8'h00},
    {16'h0002, 8'h01, 16'h8003, 8'h00, 16'h0002, 8'h00},
    {16'h0002, 8'h01, 16'h8003, 8'h00, 16'h0002, 8'h00},
    {16'h0003, 8'h01, 16'h8004, 8'h00, 16'h0002, 8'h00},
    {16'h0004, 8'h00, 16'h8004, 8'h00, 16'h0002, 8'h00},
    {16'h0005, 8'h01, 16'h8005, 8'h00, 16'h0002, 8'h00}
  };

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got=%h exp=%h", req, what, got, exp);
    end
  endtask

  function automatic string loop_req(input int i);
    if (i == 0) return "R1";
    if (i == 6 || i == 12) return "R3";
    if (i == 7 || i == 13) return "R4";
    if (i == 8) return "R8";
    return "R5";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "addr in reset", {16'h0, l_addr}, 32'h0);
    chk("R1", "halted in reset", {31'h0, h_halt}, 32'h0);
    rst_ni = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      if (i > 0) @(negedge clk);
      #1;
      chk(loop_req(i), $sformatf("loop addr c%0d", i), {16'h0, l_addr}, {16'h0, VEC[i][71:56]});
      chk(loop_req(i), $sformatf("loop data c%0d", i), {24'h0, l_data}, {24'h0, VEC[i][55:48]});
      chk("R9", $sformatf("ram addr c%0d", i), {16'h0, r_addr}, {16'h0, VEC[i][47:32]});
      chk("R9", $sformatf("ram data c%0d", i), {24'h0, r_data}, {24'h0, VEC[i][31:24]});
      chk(i < 3 ? "R2" : "R6", $sformatf("halt addr c%0d", i), {16'h0, h_addr}, {16'h0, VEC[i][23:8]});
      chk(i < 3 ? "R2" : "R6", $sformatf("halt data c%0d", i), {24'h0, h_data}, {24'h0, VEC[i][7:0]});
      chk("R6", $sformatf("halted c%0d", i), {31'h0, h_halt}, {31'h0, i >= 4});
      chk("R5", $sformatf("loop never halts c%0d", i), {31'h0, l_halt}, 32'h0);
    end

    // 20 full loop periods later the loop is at the same phase as cycle 13
    repeat (120) @(negedge clk);
    #1;
    chk("R5", "loop addr long run", {16'h0, l_addr}, 32'h5);
    chk("R4", "loop data long run", {24'h0, l_data}, 32'h1);
    chk("R6", "halt addr long run", {16'h0, h_addr}, 32'h2);
    chk("R6", "halt bus long run", {24'h0, h_data}, 32'h0);
    chk("R6", "halted long run", {31'h0, h_halt}, 32'h1);

    // reset while halted
    #2 rst_ni = 1'b0;
    #1;
    chk("R7", "halted cleared by reset", {31'h0, h_halt}, 32'h0);
    chk("R7", "addr cleared by reset", {16'h0, h_addr}, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R7", "restart data", {24'h0, h_data}, 32'h0);
    @(negedge clk); #1;
    chk("R7", "restart addr c1", {16'h0, h_addr}, 32'h1);
    chk("R7", "restart data c1", {24'h0, h_data}, 32'h2);
    repeat (3) @(negedge clk); #1;
    chk("R7", "halted again c4", {31'h0, h_halt}, 32'h1);
    chk("R7", "addr again c4", {16'h0, h_addr}, 32'h2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R5 watchdog: got=timeout exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule